// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This unit performs the partial-word left and right load and store operations of a little-endian 32-bit CPU. A request carries the operation, the byte address, the register operand and a destination register index. The unit always reads the aligned word that holds the addressed byte. The low two address bits select how memory bytes and register bytes are combined.

For the two load forms, the merged value goes back to the register file through a write-back port. For the two store forms, the unit does a read-modify-write. It merges the register bytes into the word it read and writes the result to the same aligned address. The memory model and the address computation sit outside the unit. They connect through a read request/valid pair and a write request/acknowledge pair.

Operation encoding on `reqOp`: 0 load-left, 1 load-right, 2 store-left, 3 store-right. The unit accepts a new request only while `reqReady` is high.

Top module: `partWordUnit`

## Requirements
- R1: After reset, `reqReady` is 1 and `memRdEn`, `memWrEn`, `done` and `wbEn` are all 0.
- R2: The cycle after a request is accepted, `memRdEn` is 1 and `memAddr` equals the request address with bits [1:0] cleared. A store's write uses the same address.
- R3: Load-left with offset k gives `(reg & M) | (mem << S)`. For k = 0, 1, 2, 3, M is 0x00FFFFFF, 0x0000FFFF, 0x000000FF, 0 and S is 24, 16, 8, 0.
- R4: Load-right with offset k gives `(reg & M) | (mem >> S)`. For k = 0, 1, 2, 3, M is 0, 0xFF000000, 0xFFFF0000, 0xFFFFFF00 and S is 0, 8, 16, 24.
- R5: Store-left with offset k writes `(reg >> S) | (mem & M)`. For k = 0, 1, 2, 3, S is 24, 16, 8, 0 and M is 0xFFFFFF00, 0xFFFF0000, 0xFF000000, 0.
- R6: Store-right with offset k writes `(reg << S) | (mem & M)`. For k = 0, 1, 2, 3, S is 0, 8, 16, 24 and M is 0, 0xFF, 0xFFFF, 0xFFFFFF.
- R7: A load whose destination index is 0 still issues the memory read and pulses `done`, but `wbEn` stays 0.
- R8: For a load, `done` and `wbEn` (when the destination is nonzero) are high for exactly one cycle, one cycle after `memRdValid`. No write is issued.
- R9: For a store, `memWrEn` rises the cycle after `memRdValid` and stays high until `memWrAck`. `done` is a one-cycle pulse the cycle after the acknowledge. `wbEn` stays 0. Read and write requests are never high together.
- R10: Requests that arrive while `reqReady` is 0 are ignored. Operation, offset, register value and destination are captured at acceptance, so later changes on the request inputs do not affect the operation in flight.
- R11: `memRdEn` stays high until `memRdValid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | Operation code |
| reqAddr | input | 32 | Byte address |
| reqReg | input | 32 | Register operand (old destination value for loads, source for stores) |
| reqDest | input | 5 | Destination register index for loads |
| reqReady | output | 1 | Unit idle, request accepted this cycle if valid |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 32 | Aligned word address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Aligned memory word |
| memWrEn | output | 1 | Memory write request |
| memWrData | output | 32 | Merged word to write |
| memWrAck | input | 1 | Write accepted |
| done | output | 1 | Operation complete pulse |
| wbEn | output | 1 | Register write-back enable |
| wbDest | output | 5 | Write-back register index |
| wbData | output | 32 | Merged load result |

## Verification
Two events can coincide. A fresh request can arrive in the same cycle that the unit finishes the previous operation, or while it waits on memory. In that case the held request inputs could overwrite the captured operation or start a second read. The bench keeps `reqValid` high with a different operation, address and register value from acceptance through the `done` cycle. It then checks that the merged result still matches the first request and that no read is issued after `done`. The bench also switches the request inputs to junk right after acceptance, so that any late capture shows up as a wrong merged value.

// File: rtl/pwPkg.sv
package pwPkg;
  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'd0,
    OP_LOAD_RIGHT  = 2'd1,
    OP_STORE_LEFT  = 2'd2,
    OP_STORE_RIGHT = 2'd3
  } pwOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request fields
    logic latchMerge; // latch merged word from read data
    logic finish;     // completion cycle
  } pwStrobe_t;
endpackage

// File: rtl/pwCtrl.sv
module pwCtrl
  import pwPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isStore,
  input  logic      memRdValid,
  input  logic      memWrAck,
  output pwStrobe_t strobe,
  output logic      reqReady,
  output logic      memRdEn,
  output logic      memWrEn,
  output logic      done
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FIN} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_READ;
      ST_READ:  if (memRdValid) stateNext = isStore ? ST_WRITE : ST_FIN;
      ST_WRITE: if (memWrAck) stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady          = (state == ST_IDLE);
  assign memRdEn           = (state == ST_READ);
  assign memWrEn           = (state == ST_WRITE);
  assign done              = (state == ST_FIN);
  assign strobe.capture    = reqReady && reqValid;
  assign strobe.latchMerge = memRdEn && memRdValid;
  assign strobe.finish     = done;

  // R11: read request held until data arrives
  assert_rd_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memRdValid) |=> memRdEn);
  // R9: write only follows a completed read
  assert_wr_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEn) |-> $past(memRdValid));
  // R9: write request held until acknowledge
  assert_wr_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memWrAck) |=> memWrEn);
  // R9: read and write never overlap
  assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/pwData.sv
module pwData
  import pwPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strobe,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqReg,
  input  logic [IDX_W-1:0]  reqDest,
  input  logic [DATA_W-1:0] memRdData,
  output logic              isStore,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbDest,
  output logic [DATA_W-1:0] wbData
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int SH_W  = OFF_W + 3;

  pwOp_e             opReg;
  logic [OFF_W-1:0]  offReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] regReg;
  logic [IDX_W-1:0]  destReg;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] mergeWord;
  logic [SH_W-1:0]   loShift, hiShift;
  logic [DATA_W-1:0] ones;

  assign ones    = '1;
  assign loShift = {offReg, 3'b000};   // 8 * offset
  assign hiShift = {~offReg, 3'b000};  // 8 * (LANES-1-offset)

  always_comb begin
    unique case (opReg)
      OP_LOAD_LEFT:   mergeWord = (regReg & ~(ones << hiShift)) | (memRdData << hiShift);
      OP_LOAD_RIGHT:  mergeWord = (regReg & ~(ones >> loShift)) | (memRdData >> loShift);
      OP_STORE_LEFT:  mergeWord = (regReg >> hiShift) | (memRdData & ~(ones >> hiShift));
      OP_STORE_RIGHT: mergeWord = (regReg << loShift) | (memRdData & ~(ones << loShift));
      default:        mergeWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg     <= OP_LOAD_LEFT;
      offReg    <= '0;
      addrReg   <= '0;
      regReg    <= '0;
      destReg   <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.capture) begin
        opReg   <= pwOp_e'(reqOp);
        offReg  <= reqAddr[OFF_W-1:0];
        addrReg <= {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        regReg  <= reqReg;
        destReg <= reqDest;
      end
      if (strobe.latchMerge) resultReg <= mergeWord;
    end
  end

  assign isStore   = opReg[1];
  assign memAddr   = addrReg;
  assign memWrData = resultReg;
  assign wbDest    = destReg;
  assign wbData    = resultReg;
  assign wbEn      = strobe.finish && !opReg[1] && (destReg != '0);

  // R10: captured request fields change only at acceptance
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(opReg) && $stable(offReg) && $stable(regReg) && $stable(destReg)));
  // R2: merge is taken while the address is word aligned
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchMerge |-> (memAddr[OFF_W-1:0] == '0));
  // R7: write-back only at completion
  assert_wb_at_finish_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> strobe.finish);
endmodule

// File: rtl/partWordUnit.sv
module partWordUnit
  import pwPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqReg,
  input  logic [IDX_W-1:0]  reqDest,
  output logic              reqReady,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrAck,
  output logic              done,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbDest,
  output logic [DATA_W-1:0] wbData
);
  pwStrobe_t strobe;
  logic      isStore;

  pwCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isStore(isStore),
    .memRdValid(memRdValid), .memWrAck(memWrAck), .strobe(strobe),
    .reqReady(reqReady), .memRdEn(memRdEn), .memWrEn(memWrEn), .done(done)
  );

  pwData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqReg(reqReg), .reqDest(reqDest), .memRdData(memRdData), .isStore(isStore),
    .memAddr(memAddr), .memWrData(memWrData), .wbEn(wbEn), .wbDest(wbDest),
    .wbData(wbData)
  );
endmodule

// File: tb/partWordUnit_test.sv
`timescale 1ns/1ps
module partWordUnit_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic [1:0]  reqOp = 0;
  logic [31:0] reqAddr = 0;
  logic [31:0] reqReg = 0;
  logic [4:0]  reqDest = 0;
  logic        reqReady, memRdEn, memWrEn, done, wbEn;
  logic [31:0] memAddr, memWrData, wbData;
  logic [4:0]  wbDest;
  logic        memRdValid = 0;
  logic [31:0] memRdData = 0;
  logic        memWrAck = 0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  partWordUnit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqReg(reqReg), .reqDest(reqDest), .reqReady(reqReady), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .memWrAck(memWrAck), .done(done),
    .wbEn(wbEn), .wbDest(wbDest), .wbData(wbData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expMerge(input logic [1:0] op, input logic [1:0] k,
                                           input logic [31:0] r, input logic [31:0] m);
    logic [31:0] mk;
    int sh;
    case (op)
      2'd0: begin  // R3
        case (k) 0: begin mk = 32'h00FFFFFF; sh = 24; end
                 1: begin mk = 32'h0000FFFF; sh = 16; end
                 2: begin mk = 32'h000000FF; sh = 8;  end
                 default: begin mk = 32'h0; sh = 0; end endcase
        return (r & mk) | (m << sh);
      end
      2'd1: begin  // R4
        case (k) 0: begin mk = 32'h0;        sh = 0;  end
                 1: begin mk = 32'hFF000000; sh = 8;  end
                 2: begin mk = 32'hFFFF0000; sh = 16; end
                 default: begin mk = 32'hFFFFFF00; sh = 24; end endcase
        return (r & mk) | (m >> sh);
      end
      2'd2: begin  // R5
        case (k) 0: begin mk = 32'hFFFFFF00; sh = 24; end
                 1: begin mk = 32'hFFFF0000; sh = 16; end
                 2: begin mk = 32'hFF000000; sh = 8;  end
                 default: begin mk = 32'h0; sh = 0; end endcase
        return (r >> sh) | (m & mk);
      end
      default: begin  // R6
        case (k) 0: begin mk = 32'h0;      sh = 0;  end
                 1: begin mk = 32'hFF;     sh = 8;  end
                 2: begin mk = 32'hFFFF;   sh = 16; end
                 default: begin mk = 32'hFFFFFF; sh = 24; end endcase
        return (r << sh) | (m & mk);
      end
    endcase
  endfunction

  // One operation; poke keeps a conflicting request asserted while busy (R10)
  task automatic runOp(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] r,
                       input logic [4:0] dest, input logic [31:0] m,
                       input int rdLat, input int ackLat, input bit poke);
    logic [31:0] exp;
    string tag;
    exp = expMerge(op, addr[1:0], r, m);
    tag = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R6";
    @(negedge clk);
    check("R10 ready before request", reqReady, 1);
    reqValid = 1; reqOp = op; reqAddr = addr; reqReg = r; reqDest = dest;
    @(negedge clk);
    // junk on inputs after acceptance
    reqValid = poke; reqOp = ~op; reqAddr = ~addr; reqReg = ~r; reqDest = ~dest;
    check("R2 read issued", memRdEn, 1);
    check("R2 aligned addr", memAddr, {addr[31:2], 2'b00});
    for (int i = 0; i < rdLat; i++) begin
      @(negedge clk);
      check("R11 read held", memRdEn, 1);
    end
    memRdValid = 1; memRdData = m;
    @(negedge clk);
    memRdValid = 0; memRdData = 32'hDEAD_BEEF;
    if (!op[1]) begin
      check("R8 done after read", done, 1);
      check("R8 no write", memWrEn, 0);
      check("R7 wbEn", wbEn, (dest != 0));
      if (dest != 0) begin
        check({tag, " load merge"}, wbData, exp);
        check("R10 wbDest", wbDest, dest);
      end
    end else begin
      check("R9 no early done", done, 0);
      check("R9 write issued", memWrEn, 1);
      check("R9 write addr", memAddr, {addr[31:2], 2'b00});
      check({tag, " store merge"}, memWrData, exp);
      for (int i = 0; i < ackLat; i++) begin
        @(negedge clk);
        check("R9 write held", memWrEn, 1);
      end
      memWrAck = 1;
      @(negedge clk);
      memWrAck = 0;
      check("R9 done after ack", done, 1);
      check("R9 write dropped", memWrEn, 0);
      check("R9 no writeback", wbEn, 0);
    end
    reqValid = 0;
    @(negedge clk);
    check("R8 done pulse", done, 0);
    check("R10 no extra read", memRdEn, 0);
    check("R10 idle again", reqReady, 1);
  endtask

  task automatic testReset();
    check("R1 ready", reqReady, 1);
    check("R1 rd", memRdEn, 0);
    check("R1 wr", memWrEn, 0);
    check("R1 done", done, 0);
    check("R1 wb", wbEn, 0);
  endtask

  task automatic testAllOffsets(input logic [31:0] r, input logic [31:0] m, input int lat);
    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 4; k++)
        runOp(op[1:0], 32'h0000_1230 | k, r, 5'd7, m, lat, lat, 0);
  endtask

  task automatic testDestZero();
    runOp(2'd0, 32'h0000_0041, 32'h1234_5678, 5'd0, 32'hCAFE_F00D, 1, 0, 0);  // R7
    runOp(2'd1, 32'h0000_0042, 32'h1234_5678, 5'd0, 32'hCAFE_F00D, 0, 0, 0);  // R7
  endtask

  task automatic testBusyRequests();
    runOp(2'd3, 32'h8000_0006, 32'h0102_0304, 5'd3, 32'hA0B0_C0D0, 2, 3, 1);  // R10
    runOp(2'd0, 32'h8000_0009, 32'hFFFF_FFFF, 5'd9, 32'h5566_7788, 3, 0, 1);  // R10
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testAllOffsets(32'hAABB_CCDD, 32'h1122_3344, 0);
    testAllOffsets(32'h8765_4321, 32'hF0E1_D2C3, 2);
    testDestZero();
    testBusyRequests();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule